// File: doc/BRIEF.md
# Address Watchpoint Unit

This block watches two address streams of a processor core: the instruction fetch address and the load/store data address. It holds eight programmable watch addresses. Watchpoints 0 to 5 look at fetches and watchpoints 6 and 7 look at data accesses. Each watchpoint can match one exact address. Watchpoints can also be combined two by two, (0,1), (2,3), (4,5) and (6,7), to match an inclusive address range. Each data watchpoint has a qualifier that selects reads, writes or both.

Every watchpoint has a 16-bit occurrence counter. A debug event is requested only when a counter runs out, so a debugger can stop on, for example, the fifth pass through a loop. The per-watchpoint hit flags and the debug-event pulse are registered. They appear in the cycle after the access that caused them.

Software programs the unit through a simple write port (address, data, write enable). Address bits [4:3] select the kind of register, and bits [2:0] select the watchpoint:
- 00: watch address.
- 01: count. Writing a count loads both the reload value and the live counter from data bits [15:0].
- 10: control word.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset all outputs are 0, all watchpoints are disabled, all watch addresses are 0, and all counts are 0.
- R2: An enabled fetch watchpoint j (0..5) that is not in a range pair raises iw_hit[j] in the cycle after a fetch with iaddr_vld=1 and iaddr equal to its watch address.
- R3: A watchpoint whose enable bit (control bit j) is 0 never raises its hit flag. Matches while it is disabled leave its counter unchanged.
- R4: A fetch with iaddr_vld=0 raises no iw_hit bit and no debug event.
- R5: When control bit 8+p is set for fetch pair p (watchpoints 2p and 2p+1), iw_hit[2p] is raised for lo <= iaddr <= hi, both bounds inclusive. Here lo is the address of watchpoint 2p and hi is the address of watchpoint 2p+1. iw_hit[2p+1] stays 0 in this mode.
- R6: Data watchpoint d (watchpoint 6+d) matches only when daddr_vld=1. Qualifier bit 12+2d must be set to match a read (daddr_wr=0), and qualifier bit 13+2d must be set to match a write (daddr_wr=1). A data hit is shown on dw_hit[d].
- R7: When control bit 11 is set, dw_hit[0] is raised for an inclusive range between the addresses of watchpoints 6 and 7, using the qualifier of watchpoint 6. dw_hit[1] stays 0 in this mode.
- R8: With a count N >= 2 loaded, the debug event fires on every N-th hit of that watchpoint, and the counter then reloads N. With N of 0 or 1, every hit fires.
- R9: dbg_evt is registered. It goes high in the cycle after the hit that expires a counter, lasts one cycle, and the hit flags clear when no access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iaddr | input | 32 | Instruction fetch address |
| iaddr_vld | input | 1 | Fetch address valid |
| daddr | input | 32 | Data access address |
| daddr_vld | input | 1 | Data access valid |
| daddr_wr | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| iw_hit | output | 6 | Registered fetch watchpoint hits |
| dw_hit | output | 2 | Registered data watchpoint hits |
| dbg_evt | output | 1 | One-cycle debug event request |

## Verification
A wrong comparator or range bound shows on the hit flags one cycle after the offending access. The sweeps step across each bound to catch off-by-one errors at once. A counter that decrements too often, decrements while disabled, or fails to reload misplaces a dbg_evt pulse, but only at the next expiry, which can be several hits later. For this reason the bench keeps a running model of every counter and checks dbg_evt on every access.

// File: rtl/awu_pkg.sv
package awu_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Configuration register groups, selected by the top two cfg_addr bits
  typedef enum logic [1:0] {
    SEL_WATCH = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  // Bit positions inside a two-bit data qualifier
  localparam int QUAL_RD = 0;
  localparam int QUAL_WR = 1;
endpackage

// File: rtl/awu_pair_cmp.sv
module awu_pair_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          rng,
  input  logic          en_lo,
  input  logic          en_hi,
  input  logic          ok_lo,
  input  logic          ok_hi,
  output logic          m_lo,
  output logic          m_hi
);
  timeunit 1ns;
  timeprecision 1ps;

  logic eq_lo, eq_hi, in_rng;

  always_comb begin
    eq_lo  = (addr == lo);
    eq_hi  = (addr == hi);
    in_rng = (addr >= lo) && (addr <= hi);
    m_lo   = en_lo & ok_lo & (rng ? in_rng : eq_lo);
    m_hi   = en_hi & ok_hi & ~rng & eq_hi;
  end
endmodule

// File: rtl/awu_counter.sv
module awu_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          hit,
  output logic          fire
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic          expire, cnt_en;

  always_comb begin
    expire = (cnt_q <= CW'(1));
    fire   = hit & expire;
    cnt_en = load | hit;
    cnt_d  = cnt_q;
    rld_d  = rld_q;
    if (load) begin
      cnt_d = load_val;
      rld_d = load_val;
    end else if (hit) begin
      cnt_d = expire ? rld_q : cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !hit) |=> $stable(cnt_q)); // R3
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load && cnt_q == CW'(1)) |=> (cnt_q == $past(rld_q))); // R8
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int N_IW = 6,
  parameter int N_DW = 2,
  parameter int CW   = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [AW-1:0]                     iaddr,
  input  logic                              iaddr_vld,
  input  logic [AW-1:0]                     daddr,
  input  logic                              daddr_vld,
  input  logic                              daddr_wr,
  input  logic                              cfg_we,
  input  logic [$clog2(N_IW+N_DW)+1:0]      cfg_addr,
  input  logic [AW-1:0]                     cfg_wdata,
  output logic [N_IW-1:0]                   iw_hit,
  output logic [N_DW-1:0]                   dw_hit,
  output logic                              dbg_evt
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N_WP    = N_IW + N_DW;
  localparam int N_PR    = N_WP / 2;
  localparam int SEL_W   = $clog2(N_WP);
  localparam int CA_W    = SEL_W + 2;
  localparam int RNG_LSB = N_WP;
  localparam int Q_LSB   = N_WP + N_PR;
  localparam int CTRL_W  = Q_LSB + 2 * N_DW;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // Configuration decode
  cfg_sel_e         sel;
  logic [SEL_W-1:0] idx;
  logic             ctrl_we;
  logic [N_WP-1:0]  watch_we, cnt_ld;

  always_comb begin
    sel     = cfg_sel_e'(cfg_addr[CA_W-1 -: 2]);
    idx     = cfg_addr[SEL_W-1:0];
    ctrl_we = cfg_we && (sel == SEL_CTRL);
    for (int k = 0; k < N_WP; k++) begin
      watch_we[k] = cfg_we && (sel == SEL_WATCH) && (idx == SEL_W'(k));
      cnt_ld[k]   = cfg_we && (sel == SEL_COUNT) && (idx == SEL_W'(k));
    end
  end

  logic [CTRL_W-1:0] ctrl_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= cfg_wdata[CTRL_W-1:0];
  end

  logic [AW-1:0]   watch_q [N_WP];
  logic [N_WP-1:0] acc_ok, match, fire;

  for (genvar j = 0; j < N_WP; j++) begin : g_wp
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)         watch_q[j] <= '0;
      else if (watch_we[j]) watch_q[j] <= cfg_wdata;
    end

    if (j < N_IW) begin : g_iok
      assign acc_ok[j] = iaddr_vld;
    end else begin : g_dok
      localparam int QB = Q_LSB + 2 * (j - N_IW);
      assign acc_ok[j] = daddr_vld &
        (daddr_wr ? ctrl_q[QB + QUAL_WR] : ctrl_q[QB + QUAL_RD]);
      AST_DATA_WR_QUAL: assert property (@(posedge clk) disable iff (!rst_i_n)
        (daddr_vld && daddr_wr && !ctrl_q[QB + QUAL_WR]) |=> !iw_dw_hit_q[j]); // R6
    end

    awu_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .load     (cnt_ld[j]),
      .load_val (cfg_wdata[CW-1:0]),
      .hit      (match[j]),
      .fire     (fire[j])
    );

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_i_n)
      !ctrl_q[j] |=> !iw_dw_hit_q[j]); // R3
  end

  for (genvar p = 0; p < N_PR; p++) begin : g_pair
    logic [AW-1:0] a_src;
    if (2 * p < N_IW) begin : g_src_i
      assign a_src = iaddr;
    end else begin : g_src_d
      assign a_src = daddr;
    end

    awu_pair_cmp #(.AW(AW)) u_cmp (
      .addr  (a_src),
      .lo    (watch_q[2*p]),
      .hi    (watch_q[2*p+1]),
      .rng   (ctrl_q[RNG_LSB+p]),
      .en_lo (ctrl_q[2*p]),
      .en_hi (ctrl_q[2*p+1]),
      .ok_lo (acc_ok[2*p]),
      .ok_hi (acc_ok[2*p+1]),
      .m_lo  (match[2*p]),
      .m_hi  (match[2*p+1])
    );

    AST_RANGE_ODD_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
      ctrl_q[RNG_LSB+p] |=> !iw_dw_hit_q[2*p+1]); // R5
  end

  // Output registers
  logic [N_WP-1:0] iw_dw_hit_q;
  logic            evt_q, evt_d;

  always_comb evt_d = |fire;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      iw_dw_hit_q <= '0;
      evt_q       <= 1'b0;
    end else begin
      iw_dw_hit_q <= match;
      evt_q       <= evt_d;
    end
  end

  assign iw_hit  = iw_dw_hit_q[N_IW-1:0];
  assign dw_hit  = iw_dw_hit_q[N_WP-1:N_IW];
  assign dbg_evt = evt_q;

  AST_EVT_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    dbg_evt |-> (iw_dw_hit_q != '0)); // R8
  AST_NO_FETCH_NO_IHIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    !iaddr_vld |=> (iw_hit == '0)); // R4
endmodule

// File: tb/addr_watch_unit_bench.sv
module addr_watch_unit_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 32, NI = 6, ND = 2, NW = 8, CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] iaddr = '0, daddr = '0, cfg_wdata = '0;
  logic          iaddr_vld = 1'b0, daddr_vld = 1'b0, daddr_wr = 1'b0, cfg_we = 1'b0;
  logic [4:0]    cfg_addr = '0;
  logic [NI-1:0] iw_hit;
  logic [ND-1:0] dw_hit;
  logic          dbg_evt;

  always #2.5 clk = ~clk;

  addr_watch_unit u_addr_watch_unit (
    .clk(clk), .rst_n(rst_n), .iaddr(iaddr), .iaddr_vld(iaddr_vld),
    .daddr(daddr), .daddr_vld(daddr_vld), .daddr_wr(daddr_wr),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .iw_hit(iw_hit), .dw_hit(dw_hit), .dbg_evt(dbg_evt)
  );

  // Bench model of the programmed state
  logic [AW-1:0] m_wa  [NW];
  logic [CW-1:0] m_cnt [NW];
  logic [CW-1:0] m_rld [NW];
  logic [15:0]   m_ctrl;
  int n_chk = 0, n_fail = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a[4:3])
      2'd0: m_wa[a[2:0]] = d;
      2'd1: begin m_cnt[a[2:0]] = d[15:0]; m_rld[a[2:0]] = d[15:0]; end
      2'd2: m_ctrl = d[15:0];
      default: ;
    endcase
  endtask

  function automatic logic [NW-1:0] exp_hits(logic [31:0] ia, logic iv,
                                             logic [31:0] da, logic dv, logic dwr);
    logic [NW-1:0] h;
    h = '0;
    for (int p = 0; p < NW/2; p++) begin
      logic [31:0] a, lo, hi;
      logic ok_e, ok_o, rng;
      if (2*p < NI) begin
        a = ia; ok_e = iv; ok_o = iv;
      end else begin
        a = da;
        ok_e = dv && (dwr ? m_ctrl[12 + 2*(2*p-NI) + 1] : m_ctrl[12 + 2*(2*p-NI)]);
        ok_o = dv && (dwr ? m_ctrl[12 + 2*(2*p+1-NI) + 1] : m_ctrl[12 + 2*(2*p+1-NI)]);
      end
      rng = m_ctrl[8+p]; lo = m_wa[2*p]; hi = m_wa[2*p+1];
      h[2*p]   = m_ctrl[2*p] && ok_e && (rng ? (a >= lo && a <= hi) : (a == lo));
      h[2*p+1] = m_ctrl[2*p+1] && ok_o && !rng && (a == hi);
    end
    return h;
  endfunction

  task automatic access(string req, logic [31:0] ia, logic iv, logic [31:0] da,
                        logic dv, logic dwr, bit idle_after);
    logic [NW-1:0] h;
    logic evt;
    h = exp_hits(ia, iv, da, dv, dwr);
    evt = 1'b0;
    for (int j = 0; j < NW; j++) begin
      if (h[j]) begin
        if (m_cnt[j] <= 16'd1) begin evt = 1'b1; m_cnt[j] = m_rld[j]; end
        else m_cnt[j] = m_cnt[j] - 16'd1;
      end
    end
    @(negedge clk);
    iaddr = ia; iaddr_vld = iv; daddr = da; daddr_vld = dv; daddr_wr = dwr;
    @(negedge clk);
    iaddr_vld = 1'b0; daddr_vld = 1'b0;
    check(req, "iw_hit", 32'(iw_hit), 32'(h[NI-1:0]));
    check(req, "dw_hit", 32'(dw_hit), 32'(h[NW-1:NI]));
    check(req, "dbg_evt", 32'(dbg_evt), 32'(evt));
    if (idle_after) begin
      @(negedge clk);
      check("R9", "idle flags", {23'd0, dbg_evt, dw_hit, iw_hit}, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int j = 0; j < NW; j++) begin m_wa[j] = '0; m_cnt[j] = '0; m_rld[j] = '0; end
    m_ctrl = '0;
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", {23'd0, dbg_evt, dw_hit, iw_hit}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "outputs after reset", {23'd0, dbg_evt, dw_hit, iw_hit}, 32'd0);
    // R1: all disabled, addresses 0: an access to 0 must not hit
    access("R1", 32'h0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
    access("R1", 32'h0, 1'b1, 32'h0, 1'b1, 1'b1, 1'b0);

    for (int j = 0; j < NW; j++) cfg(5'(j), 32'h1000 + 32'(j) * 32'h10);
    cfg(5'h10, 32'h0000_F0FF);

    // R2: exact fetch matches and neighbours
    for (int j = 0; j < NI; j++) begin
      access("R2", m_wa[j], 1'b1, 32'h0, 1'b0, 1'b0, 1'b1);
      access("R2", m_wa[j] + 1, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
      access("R2", m_wa[j] - 1, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
    end
    // R4: invalid fetch
    for (int j = 0; j < NI; j++) access("R4", m_wa[j], 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    // R3: every fetch enable mask
    for (int mask = 0; mask < 64; mask++) begin
      cfg(5'h10, 32'h0000_F0C0 | 32'(mask));
      for (int j = 0; j < NI; j++) access("R3", m_wa[j], 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
    end

    // R5: range mode per fetch pair, then all pairs at once
    for (int p = 0; p < 3; p++) begin
      cfg(5'(2*p), 32'h2000 + 32'(p) * 32'h100);
      cfg(5'(2*p+1), 32'h2020 + 32'(p) * 32'h100);
    end
    for (int p = 0; p < 4; p++) begin
      cfg(5'h10, (p == 3) ? 32'h0000_F7FF : (32'h0000_F0FF | (32'h100 << p)));
      for (int q = 0; q < 3; q++)
        for (int a = -2; a <= 34; a++)
          access("R5", m_wa[2*q] + 32'(a), 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
    end
    // R5: inverted bounds never match in range mode
    cfg(5'h0, 32'h2400); cfg(5'h1, 32'h23F0); cfg(5'h10, 32'h0000_F1FF);
    for (int a = 32'h23EE; a <= 32'h2402; a++) access("R5", 32'(a), 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);

    // R6: data qualifiers, both directions, both data watchpoints
    for (int q = 0; q < 16; q++) begin
      cfg(5'h10, 32'h0000_00FF | (32'(q) << 12));
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < ND; d++) begin
          access("R6", 32'h0, 1'b0, m_wa[NI+d], 1'b1, 1'(w), 1'b0);
          access("R6", 32'h0, 1'b0, m_wa[NI+d], 1'b0, 1'(w), 1'b0);
        end
    end

    // R7: data range pair
    cfg(5'h6, 32'h3000); cfg(5'h7, 32'h3010);
    for (int q = 1; q < 4; q++) begin
      cfg(5'h10, 32'h0000_C8FF | (32'(q) << 12));
      for (int w = 0; w < 2; w++)
        for (int a = 32'h2FFE; a <= 32'h3012; a++)
          access("R7", 32'h0, 1'b0, 32'(a), 1'b1, 1'(w), 1'b0);
    end

    // R8: occurrence counts
    for (int j = 0; j < NW; j++) cfg(5'(j), 32'h4000 + 32'(j) * 32'h10);
    cfg(5'h10, 32'h0000_F0FF);
    cfg(5'h08, 32'd3);
    for (int k = 0; k < 7; k++) access("R8", m_wa[0], 1'b1, 32'h0, 1'b0, 1'b0, 1'b1);
    cfg(5'h09, 32'd1);
    for (int k = 0; k < 3; k++) access("R8", m_wa[1], 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
    cfg(5'h0E, 32'd2); cfg(5'h0C, 32'd4);
    for (int k = 0; k < 9; k++) access("R8", m_wa[4], 1'b1, m_wa[6], 1'b1, 1'(k % 2), 1'b1);

    // R3: no decrement while disabled
    cfg(5'h0A, 32'd2);
    cfg(5'h10, 32'h0000_F0FB);
    for (int k = 0; k < 3; k++) access("R3", m_wa[2], 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
    cfg(5'h10, 32'h0000_F0FF);
    for (int k = 0; k < 4; k++) access("R3", m_wa[2], 1'b1, 32'h0, 1'b0, 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule